// File: doc/BRIEF.md
# Block Move Operand Fetch Sequencer

This block takes a two-word block-move instruction and resolves the operands that a transfer engine needs: a 24-bit byte count and a 32-bit data address. It supports three ways of finding them. In direct form both come from the instruction. In pointer form the count comes from the instruction and the address is read from memory at the location the second word names. In table form a signed displacement in the second word is added to a structure base register, and the count and then the address are read from consecutive words at that location.

Extra operand words are read through a simple 32-bit memory read port. The port holds a request and an address until the memory answers with a valid strobe. The resolved count and address are committed together. A single-cycle done pulse marks the commit. An instruction whose type field is not block move, or that asks for pointer and table forms at once, raises a single-cycle illegal pulse and changes nothing.

Top module: `bmove_operand_seq`

## Requirements
- R1: After reset, `done`, `illegal`, `mem_req` and `busy` are low, and `count_out` and `addr_out` are zero.
- R2: Direct form (bits 31-30 = 00, bit 29 = 0, bit 28 = 0): `count_out` takes bits 23-0 of word 0 and `addr_out` takes word 1. No memory read is made, and `done` rises in the cycle after `start` is sampled.
- R3: Pointer form (bits 31-30 = 00, bit 29 = 1, bit 28 = 0): exactly one read is made, at the address in word 1. `addr_out` takes the full 32-bit read data and `count_out` takes bits 23-0 of word 0.
- R4: Table form (bits 31-30 = 00, bit 29 = 0, bit 28 = 1): the fetch address T is `base_addr` plus bits 23-0 of word 1, sign-extended to 32 bits. Two reads are made in order, first at T and then at T+4. `count_out` takes bits 23-0 of the first read and `addr_out` takes the second read. The count field of word 0 is not used.
- R5: In table form, bits 31-24 of word 1 have no effect on the fetch addresses or on the results.
- R6: When bits 29 and 28 are both set, `illegal` pulses for one cycle in the cycle after `start`. No read is made, `done` stays low, and `count_out` and `addr_out` keep their previous values.
- R7: When bits 31-30 of word 0 are not 00, the instruction is handled as in R6.
- R8: `done` and `illegal` are never high longer than one cycle or at the same time. `start` is ignored while `busy` is high, and `busy` covers every cycle from acceptance up to and including the done or illegal pulse.
- R9: Once `mem_req` is raised, it and `mem_addr` stay unchanged until a cycle in which `mem_valid` is high.
- R10: Table-form address arithmetic wraps modulo 2^32, both for T and for T+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the instruction on `instr_w0`/`instr_w1` when not busy |
| instr_w0 | input | 32 | First instruction word (type, form bits, count field) |
| instr_w1 | input | 32 | Second instruction word (address, pointer or displacement) |
| base_addr | input | 32 | Structure base register, longword aligned |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Read address |
| mem_rdata | input | 32 | Read data, taken when `mem_valid` is high |
| mem_valid | input | 1 | Read data valid |
| busy | output | 1 | Instruction in progress; `start` is ignored |
| done | output | 1 | One-cycle pulse when the operands are committed |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| count_out | output | 24 | Resolved byte count |
| addr_out | output | 32 | Resolved data address |

## Verification
The hardest cases to reach are in table form: a displacement that sends T, or T+4, across the top of the address space, and a new `start` that arrives while a fetch is still waiting for memory. The bench sweeps every form against a set of base values that includes one just below the top of memory. It uses displacements at both ends of the signed 24-bit range and fills the ignored upper byte of word 1 with changing data. Its memory model answers after a configurable latency of 0 to 3 cycles, so that a `start` can be pushed into a pending read and dropped requests can be spotted in the fetch log.

// File: rtl/bmo_pkg.sv
package bmo_pkg;

  typedef enum logic [1:0] {
    FORM_DIRECT = 2'd0,
    FORM_PTR    = 2'd1,
    FORM_TABLE  = 2'd2,
    FORM_REJECT = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PTR  = 2'd1,
    SQ_CNT  = 2'd2,
    SQ_ADR  = 2'd3
  } seq_e;

  localparam logic [1:0] KIND_BLOCK_MOVE = 2'b00;

endpackage

// File: rtl/bmo_decode.sv
module bmo_decode
  import bmo_pkg::*;
#(
  parameter int HDR_W = 4
) (
  input  logic [HDR_W-1:0] hdr,
  output form_e            form,
  output logic             bad_kind,
  output logic             bad_combo
);
  localparam int KIND_HI = HDR_W - 1;
  localparam int PTR_BIT = HDR_W - 3;
  localparam int TBL_BIT = HDR_W - 4;

  logic [1:0] kind;
  logic       use_ptr;
  logic       use_tbl;

  assign kind      = hdr[KIND_HI -: 2];
  assign use_ptr   = hdr[PTR_BIT];
  assign use_tbl   = hdr[TBL_BIT];
  assign bad_kind  = (kind != KIND_BLOCK_MOVE);
  assign bad_combo = use_ptr & use_tbl;

  always_comb begin
    if (bad_kind || bad_combo) form = FORM_REJECT;
    else if (use_ptr)          form = FORM_PTR;
    else if (use_tbl)          form = FORM_TABLE;
    else                       form = FORM_DIRECT;
  end

  always_comb begin
    a_r6_reject_on_combo: assert (!bad_combo || form == FORM_REJECT);
    a_r7_reject_on_kind:  assert (!bad_kind  || form == FORM_REJECT);
  end
endmodule

// File: rtl/bmo_addr_gen.sv
module bmo_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 24,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] widen_signed(input logic [OFF_W-1:0] d);
    return {{EXT_W{d[OFF_W-1]}}, d};
  endfunction

  function automatic logic [ADDR_W-1:0] rel_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [OFF_W-1:0]  d);
    return b + widen_signed(d);
  endfunction

  function automatic logic [ADDR_W-1:0] step_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(WORD_BYTES);
  endfunction

  assign tbl_addr = rel_addr(base, disp);
  assign nxt_addr = step_word(cur_addr);
endmodule

// File: rtl/bmo_fsm.sv
module bmo_fsm
  import bmo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  form_e             form,
  input  logic [CNT_W-1:0]  cnt_field,
  input  logic [ADDR_W-1:0] word1,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              mem_req,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_valid,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [CNT_W-1:0]  count_out,
  output logic [ADDR_W-1:0] addr_out
);
  seq_e              sq_q;
  logic [ADDR_W-1:0] fa_q;
  logic [CNT_W-1:0]  cnt_hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] adr_q;
  logic              done_q;
  logic              ill_q;

  logic ev_accept;
  logic ev_beat;
  logic ev_commit;

  assign busy      = (sq_q != SQ_IDLE) | done_q | ill_q;
  assign ev_accept = start & ~busy;
  assign ev_beat   = (sq_q != SQ_IDLE) & mem_valid;
  assign ev_commit = ev_beat & ((sq_q == SQ_PTR) | (sq_q == SQ_ADR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q       <= SQ_IDLE;
      fa_q       <= '0;
      cnt_hold_q <= '0;
      cnt_q      <= '0;
      adr_q      <= '0;
      done_q     <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (sq_q)
        SQ_IDLE: begin
          if (ev_accept) begin
            unique case (form)
              FORM_DIRECT: begin
                cnt_q  <= cnt_field;
                adr_q  <= word1;
                done_q <= 1'b1;
              end
              FORM_PTR: begin
                cnt_hold_q <= cnt_field;
                fa_q       <= word1;
                sq_q       <= SQ_PTR;
              end
              FORM_TABLE: begin
                fa_q <= tbl_addr;
                sq_q <= SQ_CNT;
              end
              default: ill_q <= 1'b1;
            endcase
          end
        end
        SQ_CNT: begin
          if (ev_beat) begin
            cnt_hold_q <= mem_rdata[CNT_W-1:0];
            fa_q       <= nxt_addr;
            sq_q       <= SQ_ADR;
          end
        end
        default: begin
          if (ev_commit) begin
            cnt_q  <= cnt_hold_q;
            adr_q  <= mem_rdata[ADDR_W-1:0];
            done_q <= 1'b1;
            sq_q   <= SQ_IDLE;
          end
        end
      endcase
    end
  end

  assign fetch_addr = fa_q;
  assign mem_req    = (sq_q != SQ_IDLE);
  assign done       = done_q;
  assign illegal    = ill_q;
  assign count_out  = cnt_q;
  assign addr_out   = adr_q;

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(fetch_addr));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal}));

  a_r6_reject_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req);

  a_r6_reject_keeps_operands: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(count_out) && $stable(addr_out));

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

// File: rtl/bmove_operand_seq.sv
module bmove_operand_seq
  import bmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int OFF_W      = 24,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] instr_w0,
  input  logic [ADDR_W-1:0] instr_w1,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_valid,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [CNT_W-1:0]  count_out,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HDR_W = 4;

  form_e             form;
  logic              bad_kind;
  logic              bad_combo;
  logic [ADDR_W-1:0] tbl_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] fetch_addr;

  bmo_decode #(.HDR_W(HDR_W)) u_decode (
    .hdr       (instr_w0[ADDR_W-1 -: HDR_W]),
    .form      (form),
    .bad_kind  (bad_kind),
    .bad_combo (bad_combo)
  );

  bmo_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)
  ) u_addr_gen (
    .base     (base_addr),
    .disp     (instr_w1[OFF_W-1:0]),
    .cur_addr (fetch_addr),
    .tbl_addr (tbl_addr),
    .nxt_addr (nxt_addr)
  );

  bmo_fsm #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(ADDR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .form       (form),
    .cnt_field  (instr_w0[CNT_W-1:0]),
    .word1      (instr_w1),
    .tbl_addr   (tbl_addr),
    .nxt_addr   (nxt_addr),
    .fetch_addr (fetch_addr),
    .mem_req    (mem_req),
    .mem_rdata  (mem_rdata),
    .mem_valid  (mem_valid),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .count_out  (count_out),
    .addr_out   (addr_out)
  );

  assign mem_addr = fetch_addr;

  a_r7_reject_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (bad_kind || bad_combo) |=> illegal && !mem_req);
endmodule

// File: tb/bmove_operand_seq_bench.sv
module bmove_operand_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] w0_i = '0, w1_i = '0, base_i = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_valid = 1'b0;
  logic        busy, done, illegal;
  logic [23:0] count_out;
  logic [31:0] addr_out;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wcnt = 0;
  int tot_fetch = 0;
  logic [31:0] flog [16];
  logic [23:0] exp_cnt = '0;
  logic [31:0] exp_adr = '0;

  always #5 clk = ~clk;

  bmove_operand_seq u_bmove_operand_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .instr_w0(w0_i), .instr_w1(w1_i), .base_addr(base_i),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .busy(busy), .done(done), .illegal(illegal),
    .count_out(count_out), .addr_out(addr_out)
  );

  function automatic logic [31:0] mfun(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= mem_lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= mfun(mem_addr);
        flog[tot_fetch % 16] = mem_addr;
        tot_fetch++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 direct, 1 pointer, 2 table, 3 rejected
  task automatic run_one(input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] b, input int lat, input int kind,
                         input string tag);
    int f0, nf, cyc;
    logic signed [23:0] so;
    logic [31:0] t0;
    mem_lat = lat;
    f0 = tot_fetch;
    @(negedge clk);
    w0_i = w0; w1_i = w1; base_i = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && !illegal && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    nf = tot_fetch - f0;
    so = w1[23:0];
    t0 = b + 32'(so);
    case (kind)
      0: begin
        exp_cnt = w0[23:0]; exp_adr = w1;
        chk(done && cyc == 0, {tag, " R2 done next cycle"}, 32'(cyc), 0);
        chk(nf == 0, {tag, " R2 no fetch"}, 32'(nf), 0);
      end
      1: begin
        exp_cnt = w0[23:0]; exp_adr = mfun(w1);
        chk(done, {tag, " R3 done"}, {31'b0, done}, 1);
        chk(nf == 1, {tag, " R3 one fetch"}, 32'(nf), 1);
        chk(flog[f0 % 16] == w1, {tag, " R3 pointer address"}, flog[f0 % 16], w1);
      end
      2: begin
        exp_cnt = mfun(t0) & 24'hFF_FFFF; exp_adr = mfun(t0 + 32'd4);
        chk(done, {tag, " R4 done"}, {31'b0, done}, 1);
        chk(nf == 2, {tag, " R4 two fetches"}, 32'(nf), 2);
        chk(flog[f0 % 16] == t0, {tag, " R4 R5 R10 first fetch"}, flog[f0 % 16], t0);
        chk(flog[(f0 + 1) % 16] == t0 + 32'd4, {tag, " R4 R10 second fetch"},
            flog[(f0 + 1) % 16], t0 + 32'd4);
      end
      default: begin
        chk(illegal && !done && cyc == 0, {tag, " R6 R7 illegal pulse"},
            {30'b0, illegal, done}, 32'h2);
        chk(nf == 0, {tag, " R6 R7 no fetch"}, 32'(nf), 0);
      end
    endcase
    chk(count_out == exp_cnt, {tag, " count"}, {8'h0, count_out}, {8'h0, exp_cnt});
    chk(addr_out == exp_adr, {tag, " address"}, addr_out, exp_adr);
    @(negedge clk);
    chk(!done && !illegal, {tag, " R8 single-cycle pulse"}, {30'b0, done, illegal}, 0);
    chk(!busy, {tag, " R8 busy clear after pulse"}, {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [4];
    logic [23:0] offs [5];
    bases[0] = 32'h0000_1000; bases[1] = 32'h8000_0010;
    bases[2] = 32'hFFFF_FFF8; bases[3] = 32'h0012_3450;
    offs[0] = 24'h000000; offs[1] = 24'h000004; offs[2] = 24'hFFFFFC;
    offs[3] = 24'h7FFFFC; offs[4] = 24'h800000;

    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!done && !illegal && !mem_req && !busy, "R1 reset flags",
        {28'b0, done, illegal, mem_req, busy}, 0);
    chk(count_out == 0 && addr_out == 0, "R1 reset operands", addr_out ^ 32'(count_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int lat = 0; lat < 4; lat++) begin
      for (int bi = 0; bi < 4; bi++) begin
        for (int oi = 0; oi < 5; oi++) begin
          logic [31:0] w1;
          logic [23:0] cf;
          logic [3:0]  ph;
          w1 = {8'(bi * 59 + oi * 17 + lat), offs[oi]};
          cf = 24'(32'h00A5_1234 * (lat + 1) + bi * 4099 + oi);
          ph = 4'(oi + bi);
          run_one({2'b00, 1'b0, 1'b0, ph, cf}, bases[bi] ^ 32'(oi << 8), 32'h0, lat, 0, "R2 direct");
          run_one({2'b00, 1'b1, 1'b0, ph, cf}, bases[bi] + 32'(oi * 4), 32'h0, lat, 1, "R3 pointer");
          run_one({2'b00, 1'b0, 1'b1, ph, cf}, w1, bases[bi], lat, 2, "R4 R5 R10 table");
          run_one({2'b00, 1'b1, 1'b1, ph, cf}, w1, bases[bi], lat, 3, "R6 both forms");
          run_one({2'(oi % 3 + 1), 2'(bi), ph, cf}, w1, bases[bi], lat, 3, "R7 other type");
        end
      end
    end

    // R5: upper byte of word 1 differs, results must match a zero upper byte
    run_one({2'b00, 2'b01, 4'h0, 24'h000111}, {8'h00, 24'hFFFFF0}, 32'h0000_2000, 1, 2, "R5 upper zero");
    run_one({2'b00, 2'b01, 4'h0, 24'h000111}, {8'hC7, 24'hFFFFF0}, 32'h0000_2000, 1, 2, "R5 upper set");

    // R10: T at top of memory, T+4 wraps to zero
    run_one({2'b00, 2'b01, 4'h0, 24'h0}, {8'h00, 24'h000004}, 32'hFFFF_FFF8, 0, 2, "R10 wrap");

    // R8: start pushed into a pending pointer fetch must be ignored
    begin
      int f0;
      mem_lat = 3;
      f0 = tot_fetch;
      @(negedge clk);
      w0_i = {2'b00, 2'b10, 4'h0, 24'h00ABCD}; w1_i = 32'h0000_4440; base_i = 32'h0;
      start = 1'b1;
      @(negedge clk);
      w0_i = {2'b00, 2'b01, 4'h0, 24'h000001}; w1_i = 32'h0000_0040; base_i = 32'h1000;
      chk(busy, "R8 busy during fetch", {31'b0, busy}, 1);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      exp_cnt = 24'h00ABCD; exp_adr = mfun(32'h0000_4440);
      chk(tot_fetch - f0 == 1, "R8 ignored start made no fetch", 32'(tot_fetch - f0), 1);
      chk(count_out == exp_cnt, "R8 count from first instruction", {8'h0, count_out}, {8'h0, exp_cnt});
      chk(addr_out == exp_adr, "R8 address from first instruction", addr_out, exp_adr);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!done && !mem_req && !illegal, "R8 no late operation",
            {29'b0, done, mem_req, illegal}, 0);
      end
      chk(tot_fetch - f0 == 1, "R9 fetch count after hold", 32'(tot_fetch - f0), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule